// File: doc/BRIEF.md
# Packed Lane Min/Max and Width Conversion Unit

This unit performs lane-oriented data shuffling for SIMD inner loops such as searching, sorting and format conversion. It takes two 32-bit operands and a 3-bit operation code, and it accepts one operation per clock. Each result appears one cycle later, together with a valid flag.

Two operations compare the two 16-bit halves of each operand on their own and return the signed minimum or maximum per lane. Two operations widen the four bytes of operand A into four 16-bit lanes of a 64-bit result, either with zero fill or with sign fill. Two operations narrow lanes with saturation: signed halfwords to unsigned bytes, or signed words to signed halfwords. Operand A always lands in the more significant part of a packed result.

The width of one operand is the parameter `DATA_W`, which must be a multiple of 32. The result is `2*DATA_W` bits wide. The lane counts follow from `DATA_W`.

Top module: `pmm_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid` is 0 and `result` is all zeros.
- R2: `out_valid` equals the `in_valid` of the previous cycle, so results have exactly one cycle of latency.
- R3: Opcode 0 returns, in each 16-bit lane of `result[31:0]`, the signed two's-complement minimum of the matching lanes of A and B. `result[63:32]` is 0.
- R4: Opcode 1 returns, in each 16-bit lane of `result[31:0]`, the signed maximum of the matching lanes of A and B. `result[63:32]` is 0.
- R5: Opcode 2 zero-extends byte k of A (bits 8k+7:8k) into `result[16k+15:16k]`, for k = 0 to 3. B is ignored.
- R6: Opcode 3 sign-extends byte k of A into `result[16k+15:16k]`, for k = 0 to 3. B is ignored.
- R7: Opcode 4 saturates each signed 16-bit lane to an unsigned byte. Negative values become 0 and values above 255 become 255. The bytes are placed as: A[31:16] to bits 31:24, A[15:0] to bits 23:16, B[31:16] to bits 15:8, B[15:0] to bits 7:0. `result[63:32]` is 0.
- R8: Opcode 5 saturates signed 32-bit A and B into the range -32768 to 32767. A goes to `result[31:16]`, B goes to `result[15:0]`, and `result[63:32]` is 0.
- R9: Opcodes 6 and 7 produce an all-zero result with `out_valid` asserted.
- R10: In a cycle with `in_valid` low, `result` keeps its previous value and the operands have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation request this cycle |
| opcode | input | 3 | Operation select (see R3 to R9) |
| op_a | input | DATA_W | Operand A |
| op_b | input | DATA_W | Operand B |
| out_valid | output | 1 | Result valid, one cycle after the request |
| result | output | 2*DATA_W | Registered result |

## Verification
The bench builds the unit with the default `DATA_W` of 32. This gives two halfword lanes for the compare operations, four byte lanes for the widening operations, and one word per operand for the narrowing to halfwords. At that width, every lane boundary and every saturation edge can be reached with hand-picked operands:
- the most negative and most positive halfwords;
- the values 255, 256 and -1 for the byte pack;
- the values 32767, 32768, -32768 and -32769 for the halfword pack.

// File: rtl/pmm_pkg.sv
package pmm_pkg;

    typedef enum logic [2:0] {
        OP_MIN2     = 3'd0,
        OP_MAX2     = 3'd1,
        OP_UNPK_Z   = 3'd2,
        OP_UNPK_S   = 3'd3,
        OP_PACK_U8  = 3'd4,
        OP_PACK_S16 = 3'd5
    } pmm_op_e;

    // Signed halfword to unsigned byte, clamped to 0..255.
    function automatic logic [7:0] sat_to_u8(input logic [15:0] v);
        if (v[15])
            return 8'h00;
        else if (|v[14:8])
            return 8'hFF;
        else
            return v[7:0];
    endfunction

    // Signed word to signed halfword, clamped to -32768..32767.
    function automatic logic [15:0] sat_to_s16(input logic [31:0] v);
        if (!v[31] && (|v[30:15]))
            return 16'h7FFF;
        else if (v[31] && !(&v[30:15]))
            return 16'h8000;
        else
            return v[15:0];
    endfunction

endpackage

// File: rtl/pmm_minmax.sv
module pmm_minmax #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              pick_max,
    output logic [DATA_W-1:0] y
);
    localparam int H_LANES = DATA_W / 16;

    for (genvar i = 0; i < H_LANES; i++) begin : g_lane
        logic signed [15:0] la, lb;
        logic               a_lt_b;
        assign la     = a[16*i +: 16];
        assign lb     = b[16*i +: 16];
        assign a_lt_b = la < lb;
        assign y[16*i +: 16] = (a_lt_b ^ pick_max) ? la : lb;
    end
endmodule

// File: rtl/pmm_unpack.sv
module pmm_unpack #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]   a,
    input  logic                sign_fill,
    output logic [2*DATA_W-1:0] y
);
    localparam int B_LANES = DATA_W / 8;

    for (genvar k = 0; k < B_LANES; k++) begin : g_byte
        logic [7:0] bt;
        logic       fill;
        assign bt   = a[8*k +: 8];
        assign fill = sign_fill & bt[7];
        assign y[16*k +: 16] = {{8{fill}}, bt};
    end
endmodule

// File: rtl/pmm_pack.sv
module pmm_pack
    import pmm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y_u8,
    output logic [DATA_W-1:0] y_s16
);
    localparam int CAT_W   = 2 * DATA_W;
    localparam int H_TOTAL = CAT_W / 16;
    localparam int W_TOTAL = CAT_W / 32;

    logic [CAT_W-1:0] cat;
    assign cat = {a, b};

    for (genvar i = 0; i < H_TOTAL; i++) begin : g_u8
        assign y_u8[8*i +: 8] = sat_to_u8(cat[16*i +: 16]);
    end

    for (genvar j = 0; j < W_TOTAL; j++) begin : g_s16
        assign y_s16[16*j +: 16] = sat_to_s16(cat[32*j +: 32]);
    end
endmodule

// File: rtl/pmm_unit.sv
module pmm_unit
    import pmm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [2:0]          opcode,
    input  logic [DATA_W-1:0]   op_a,
    input  logic [DATA_W-1:0]   op_b,
    output logic                out_valid,
    output logic [2*DATA_W-1:0] result
);
    localparam int RES_W = 2 * DATA_W;

    typedef struct packed {
        logic             vld;
        logic [RES_W-1:0] res;
    } state_t;

    state_t st_d, st_q;

    logic [DATA_W-1:0] mm_y, u8_y, s16_y;
    logic [RES_W-1:0]  unp_y;

    pmm_minmax #(.DATA_W(DATA_W)) u_minmax (
        .a(op_a), .b(op_b),
        .pick_max(opcode == OP_MAX2),
        .y(mm_y)
    );

    pmm_unpack #(.DATA_W(DATA_W)) u_unpack (
        .a(op_a),
        .sign_fill(opcode == OP_UNPK_S),
        .y(unp_y)
    );

    pmm_pack #(.DATA_W(DATA_W)) u_pack (
        .a(op_a), .b(op_b),
        .y_u8(u8_y), .y_s16(s16_y)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            case (opcode)
                OP_MIN2, OP_MAX2:      st_d.res = {{DATA_W{1'b0}}, mm_y};
                OP_UNPK_Z, OP_UNPK_S:  st_d.res = unp_y;
                OP_PACK_U8:            st_d.res = {{DATA_W{1'b0}}, u8_y};
                OP_PACK_S16:           st_d.res = {{DATA_W{1'b0}}, s16_y};
                default:               st_d.res = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    idle_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R10
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    // R9
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode[2] && opcode[1]) |=> (result == '0));

    // R3
    min_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == OP_MIN2) |=>
            ($signed(result[15:0]) <= $signed($past(op_a[15:0])) &&
             $signed(result[15:0]) <= $signed($past(op_b[15:0]))));

    // R4
    max_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == OP_MAX2) |=>
            ($signed(result[15:0]) >= $signed($past(op_a[15:0])) &&
             $signed(result[15:0]) >= $signed($past(op_b[15:0]))));

    // R6
    sign_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == OP_UNPK_S) |=> (result[15:8] == {8{result[7]}}));

    // R7
    neg_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == OP_PACK_U8 && op_b[15]) |=> (result[7:0] == 8'h00));

    // R8
    s16_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == OP_PACK_S16) |=> (result[RES_W-1:DATA_W] == '0));
endmodule

// File: tb/pmm_unit_bench.sv
module pmm_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [2:0]  opcode;
    logic [31:0] op_a, op_b;
    logic        out_valid;
    logic [63:0] result;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pmm_unit u_pmm_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .result(result)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [63:0] exp;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VT [NV] = '{
        '{3'd0, 32'h7FFF_8000, 32'h0001_0001, 64'h0000_0000_0001_8000}, // R3
        '{3'd1, 32'h7FFF_8000, 32'h0001_0001, 64'h0000_0000_7FFF_0001}, // R4
        '{3'd0, 32'hFFFF_0005, 32'h0000_FFFE, 64'h0000_0000_FFFF_FFFE}, // R3
        '{3'd1, 32'hFFFF_0005, 32'h0000_FFFE, 64'h0000_0000_0000_0005}, // R4
        '{3'd0, 32'h1234_ABCD, 32'h1234_ABCD, 64'h0000_0000_1234_ABCD}, // R3
        '{3'd2, 32'h807F_01FF, 32'h1234_5678, 64'h0080_007F_0001_00FF}, // R5
        '{3'd3, 32'h807F_01FF, 32'h1234_5678, 64'hFF80_007F_0001_FFFF}, // R6
        '{3'd4, 32'h0100_FFFF, 32'h00FF_0042, 64'h0000_0000_FF00_FF42}, // R7
        '{3'd4, 32'h8000_7FFF, 32'h0000_0080, 64'h0000_0000_00FF_0080}, // R7
        '{3'd5, 32'h0001_0000, 32'hFFFE_FFFF, 64'h0000_0000_7FFF_8000}, // R8
        '{3'd5, 32'h0000_1234, 32'hFFFF_8000, 64'h0000_0000_1234_8000}, // R8
        '{3'd5, 32'h0000_8000, 32'hFFFF_7FFF, 64'h0000_0000_7FFF_8000}, // R8
        '{3'd5, 32'h0000_7FFF, 32'hFFFF_FFFF, 64'h0000_0000_7FFF_FFFF}, // R8
        '{3'd6, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'h0000_0000_0000_0000}, // R9
        '{3'd7, 32'hA5A5_A5A5, 32'h5A5A_5A5A, 64'h0000_0000_0000_0000}  // R9
    };

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0:    return "R3";
            3'd1:    return "R4";
            3'd2:    return "R5";
            3'd3:    return "R6";
            3'd4:    return "R7";
            3'd5:    return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic v, input logic [2:0] op,
                         input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        in_valid = v; opcode = op; op_a = a; op_b = b;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b1; opcode = 3'd1;
        op_a = 32'h7FFF_7FFF; op_b = 32'h0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1", {63'd0, out_valid}, 64'd0);
        check("R1", result, 64'd0);
        @(negedge clk);
        rst_n = 1'b1; in_valid = 1'b0;
        @(posedge clk); #1;
        check("R1", result, 64'd0);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            issue(1'b1, VT[i].op, VT[i].a, VT[i].b);
            check(tag_of(VT[i].op), result, VT[i].exp);
            check("R2", {63'd0, out_valid}, 64'd1);
        end

        // R10: idle cycle with changed operands leaves result alone
        issue(1'b1, 3'd0, 32'h0003_0004, 32'h0005_0002);
        check("R3", result, 64'h0000_0000_0003_0002);
        issue(1'b0, 3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        check("R10", result, 64'h0000_0000_0003_0002);
        check("R2", {63'd0, out_valid}, 64'd0);
        issue(1'b0, 3'd5, 32'h1111_1111, 32'h2222_2222);
        check("R10", result, 64'h0000_0000_0003_0002);

        // R5: operand B has no effect on widening
        issue(1'b1, 3'd2, 32'h0102_0304, 32'hFFFF_FFFF);
        check("R5", result, 64'h0001_0002_0003_0004);

        // R2: back-to-back then idle
        issue(1'b1, 3'd6, 32'h1, 32'h1);
        check("R9", result, 64'd0);
        check("R2", {63'd0, out_valid}, 64'd1);
        issue(1'b0, 3'd0, 32'h0, 32'h0);
        check("R2", {63'd0, out_valid}, 64'd0);

        // R1: reset mid-stream clears state
        @(negedge clk); rst_n = 1'b0; in_valid = 1'b1; opcode = 3'd3; op_a = 32'h8080_8080;
        @(posedge clk); #1;
        check("R1", result, 64'd0);
        check("R1", {63'd0, out_valid}, 64'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule